// File: doc/BRIEF.md
# Twin-Predicated Element Index Sequencer

This block turns one two-operand move-style operation into a stream of register-number pairs, one pair per element that is actually moved. The source and the destination each have their own predicate mask, their own scalar/vector flag and their own base register. Each base can be replaced by a redirection entry. Two element cursors start at zero. A vector-flagged cursor skips clear bits in its own mask. After each pair, a cursor moves on only if its operand is a vector. These rules give splat, insert, extract, gather/scatter-style and plain vector copies from one sequencer. The same sequence serves register moves and loads or stores with separate source and destination predicates. For a load, the source register number names the base-address register.

An operation starts with a one-cycle `start` pulse while the block is idle. The block captures every operand input in that cycle. Pairs leave on a valid/ready stream. A pair is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered pair stays unchanged and `out_valid` stays high. No element is lost or repeated. When no further pair exists, `done` is high for one cycle and the block returns to idle.

Top module: `twin_pred_seq`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are all 0.
- R2: The effective source base is `src_redir_idx` when `src_redir_act` is 1 and `src_reg` otherwise. The destination base follows the same rule with its own redirection inputs. Emitted pairs are (source base + i, destination base + j), modulo 2^REG_W.
- R3: With both operands vector, pair k uses the k-th set source mask bit and the k-th set destination mask bit. Mask bit n belongs to element n. Emission stops when either side runs out of set bits below `vl`.
- R4: With a scalar source and a vector destination, every pair uses the source base unchanged. The destination walks the set destination bits below `vl`. The source mask has no effect.
- R5: With a vector source and a scalar destination, every pair uses the destination base unchanged. The source walks the set source bits below `vl`. The destination mask has no effect.
- R6: With both operands scalar and `vl` ≥ 1, exactly one pair (source base, destination base) is emitted, whatever the masks hold.
- R7: `done` is high for exactly one cycle, in the cycle after the final transfer, or in the cycle after `start` when no pair exists. `busy` is 0 in the cycle after `done`.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and the pair stays unchanged in the next cycle.
- R9: A `start` pulse while `busy` is 1 is ignored. The running sequence continues unchanged.
- R10: With `vl` = 0, or with a vector operand whose mask has no set bit below `vl`, no pair is emitted and `done` follows in the cycle after `start`.
- R11: Mask bits at positions ≥ `vl` never produce a pair.
- R12: When every transfer is accepted, one pair is offered in every cycle from the cycle after `start` until the last pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| vl | input | $clog2(VL_MAX+1) | Vector length |
| src_mask | input | VL_MAX | Source predicate, bit n for element n |
| dst_mask | input | VL_MAX | Destination predicate, bit n for element n |
| src_vec | input | 1 | Source operand is a vector |
| dst_vec | input | 1 | Destination operand is a vector |
| src_reg | input | REG_W | Source base register number |
| dst_reg | input | REG_W | Destination base register number |
| src_redir_act | input | 1 | Source redirection entry active |
| src_redir_idx | input | REG_W | Source redirection target |
| dst_redir_act | input | 1 | Destination redirection entry active |
| dst_redir_idx | input | REG_W | Destination redirection target |
| out_valid | output | 1 | Pair offered |
| out_ready | input | 1 | Consumer accepts the pair |
| out_src | output | REG_W | Source register number of the pair |
| out_dst | output | REG_W | Destination register number of the pair |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
A cursor that advances wrongly or skips wrongly shows up in the next transferred pair. The pair is offered one cycle after the cursor update, so a comparison against the model ordering catches it at once. A missed end or an extra pair shows as a count mismatch at `done`. A loss of the scalar-side hold shows as a changed base number in the second pair. A broken stall path shows as a changed or dropped pair in the cycle right after a refused transfer.

// File: rtl/twin_pred_pkg.sv
package twin_pred_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Operand base after optional redirection
  function automatic logic [31:0] pick_base(input logic act, input logic [31:0] idx,
                                            input logic [31:0] reg_no);
    return act ? idx : reg_no;
  endfunction
endpackage

// File: rtl/tps_first_set.sv
module tps_first_set #(
  parameter int W  = 16,
  parameter int IW = 5
) (
  input  logic [W-1:0]  bits,
  input  logic [IW-1:0] from,
  output logic          found,
  output logic [IW-1:0] pos
);
  logic [W-1:0] masked;

  always_comb begin
    masked = bits & ({W{1'b1}} << from);
    found  = 1'b0;
    pos    = '0;
    // Descending scan leaves the lowest set bit in pos
    for (int k = W - 1; k >= 0; k--) begin
      if (masked[k]) begin
        found = 1'b1;
        pos   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/tps_cursor.sv
module tps_cursor #(
  parameter int VL_MAX = 16,
  parameter int IW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic              is_vec,
  input  logic [VL_MAX-1:0] mask,
  input  logic [IW-1:0]     vl,
  output logic [IW-1:0]     eff_pos,
  output logic              past_end
);
  logic [IW-1:0] cur_q;
  logic          hit;
  logic [IW-1:0] hit_pos;

  tps_first_set #(.W(VL_MAX), .IW(IW)) u_enc (
    .bits (mask),
    .from (cur_q),
    .found(hit),
    .pos  (hit_pos)
  );

  always_comb begin
    if (!is_vec)  eff_pos = cur_q;
    else if (hit) eff_pos = hit_pos;
    else          eff_pos = IW'(VL_MAX);
    past_end = (eff_pos >= vl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_q <= '0;
    else if (clear)   cur_q <= '0;
    else if (advance) cur_q <= is_vec ? eff_pos + IW'(1) : eff_pos;
  end
endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq #(
  parameter int VL_MAX = 16,
  parameter int REG_W  = 5,
  localparam int IW    = $clog2(VL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IW-1:0]     vl,
  input  logic [VL_MAX-1:0] src_mask,
  input  logic [VL_MAX-1:0] dst_mask,
  input  logic              src_vec,
  input  logic              dst_vec,
  input  logic [REG_W-1:0]  src_reg,
  input  logic [REG_W-1:0]  dst_reg,
  input  logic              src_redir_act,
  input  logic [REG_W-1:0]  src_redir_idx,
  input  logic              dst_redir_act,
  input  logic [REG_W-1:0]  dst_redir_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [REG_W-1:0]  out_src,
  output logic [REG_W-1:0]  out_dst,
  output logic              busy,
  output logic              done
);
  import twin_pred_pkg::*;

  seq_state_e        state_q;
  logic [IW-1:0]     vl_q;
  logic [VL_MAX-1:0] smask_q, dmask_q;
  logic              svec_q, dvec_q;
  logic [REG_W-1:0]  sbase_q, dbase_q;
  logic              spent_q;

  logic              accept_start, xfer, finish;
  logic [IW-1:0]     s_pos, d_pos;
  logic              s_end, d_end;

  assign busy         = (state_q == SEQ_RUN);
  assign accept_start = start && !busy;
  assign finish       = busy && (s_end || d_end || spent_q);
  assign out_valid    = busy && !finish;
  assign done         = finish;
  assign xfer         = out_valid && out_ready;
  assign out_src      = sbase_q + REG_W'(s_pos);
  assign out_dst      = dbase_q + REG_W'(d_pos);

  tps_cursor #(.VL_MAX(VL_MAX), .IW(IW)) u_src_cur (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept_start),
    .advance (xfer),
    .is_vec  (svec_q),
    .mask    (smask_q),
    .vl      (vl_q),
    .eff_pos (s_pos),
    .past_end(s_end)
  );

  tps_cursor #(.VL_MAX(VL_MAX), .IW(IW)) u_dst_cur (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept_start),
    .advance (xfer),
    .is_vec  (dvec_q),
    .mask    (dmask_q),
    .vl      (vl_q),
    .eff_pos (d_pos),
    .past_end(d_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      vl_q    <= '0;
      smask_q <= '0;
      dmask_q <= '0;
      svec_q  <= 1'b0;
      dvec_q  <= 1'b0;
      sbase_q <= '0;
      dbase_q <= '0;
      spent_q <= 1'b0;
    end else if (accept_start) begin
      state_q <= SEQ_RUN;
      vl_q    <= vl;
      smask_q <= src_mask;
      dmask_q <= dst_mask;
      svec_q  <= src_vec;
      dvec_q  <= dst_vec;
      sbase_q <= REG_W'(pick_base(src_redir_act, 32'(src_redir_idx), 32'(src_reg)));
      dbase_q <= REG_W'(pick_base(dst_redir_act, 32'(dst_redir_idx), 32'(dst_reg)));
      spent_q <= 1'b0;
    end else if (finish) begin
      state_q <= SEQ_IDLE;
    end else if (xfer && !svec_q && !dvec_q) begin
      spent_q <= 1'b1;  // scalar-scalar: single pair only
    end
  end
endmodule

// File: rtl/twin_pred_seq_chk.sv
module twin_pred_seq_chk #(
  parameter int REG_W = 5,
  parameter int IW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [IW-1:0]    vl,
  input logic             out_valid,
  input logic             out_ready,
  input logic [REG_W-1:0] out_src,
  input logic [REG_W-1:0] out_dst,
  input logic             busy,
  input logic             done
);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_src) && $stable(out_dst));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_empty_quick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (vl == '0) |=> done);

  p_restart_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && start |=> busy);
endmodule

bind twin_pred_seq twin_pred_seq_chk #(.REG_W(REG_W), .IW(IW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .vl       (vl),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_src  (out_src),
  .out_dst  (out_dst),
  .busy     (busy),
  .done     (done)
);

// File: tb/test_twin_pred_seq.sv
`timescale 1ns/1ps
module test_twin_pred_seq;
  localparam int VL_MAX = 16;
  localparam int REG_W  = 5;
  localparam int IW     = $clog2(VL_MAX + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [IW-1:0] vl = '0;
  logic [VL_MAX-1:0] src_mask = '0, dst_mask = '0;
  logic src_vec = 0, dst_vec = 0;
  logic [REG_W-1:0] src_reg = '0, dst_reg = '0, src_redir_idx = '0, dst_redir_idx = '0;
  logic src_redir_act = 0, dst_redir_act = 0;
  logic out_valid, out_ready = 1, busy, done;
  logic [REG_W-1:0] out_src, out_dst;

  int tests = 0, fails = 0;
  logic [2*REG_W-1:0] expq[$];
  int ready_mode = 0;
  logic [7:0] lfsr = 8'h5a;
  int gap_cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  twin_pred_seq #(.VL_MAX(VL_MAX), .REG_W(REG_W)) i_twin_pred_seq (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Ready pattern, driven after the clock edge
  always @(posedge clk) begin
    #2;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= (ready_mode == 0) ? 1'b1 : lfsr[0];
  end

  // Monitor: scoreboard pop and stall-hold check (R8, R12)
  logic prev_stall = 0;
  logic [2*REG_W-1:0] prev_pair;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && {out_src, out_dst} == prev_pair, "R8", "stalled pair held",
              int'({out_src, out_dst}), int'(prev_pair));
      if (busy && !out_valid && !done) gap_cycles++;
      if (out_valid && out_ready) begin
        if (expq.size() == 0)
          check(0, "R3", "unexpected pair", int'({out_src, out_dst}), -1);
        else begin
          logic [2*REG_W-1:0] e;
          e = expq.pop_front();
          check({out_src, out_dst} == e, "R2", "pair {src,dst}",
                int'({out_src, out_dst}), int'(e));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_pair  = {out_src, out_dst};
    end
  end

  task automatic run(input string req, input int n_vl, input logic [VL_MAX-1:0] sm,
                     input logic [VL_MAX-1:0] dm, input bit sv, input bit dv,
                     input int sr, input int dr, input bit sa, input int si,
                     input bit da, input int di, input int rmode, input bit poke);
    int sb, db, i, j, n, wait_c;
    sb = sa ? si : sr;
    db = da ? di : dr;
    i = 0; j = 0; n = 0;
    while (i < n_vl && j < n_vl) begin
      if (sv) while (i < n_vl && !sm[i]) i++;
      if (dv) while (j < n_vl && !dm[j]) j++;
      if (i >= n_vl || j >= n_vl) break;
      expq.push_back({REG_W'(sb + i), REG_W'(db + j)});
      n++;
      if (sv) i++;
      if (dv) j++;
      if (!sv && !dv) break;
    end
    ready_mode = rmode;
    gap_cycles = 0;
    @(posedge clk); #2;
    vl = IW'(n_vl); src_mask = sm; dst_mask = dm; src_vec = sv; dst_vec = dv;
    src_reg = REG_W'(sr); dst_reg = REG_W'(dr); src_redir_act = sa;
    src_redir_idx = REG_W'(si); dst_redir_act = da; dst_redir_idx = REG_W'(di);
    start = 1;
    @(posedge clk); #2;
    start = 0;
    if (poke) begin  // R9: restart attempt mid-run with other operands
      vl = IW'(VL_MAX); src_mask = '1; dst_mask = '1; src_vec = 1; dst_vec = 1;
      src_reg = 5'd3; dst_reg = 5'd9; start = 1;
      @(posedge clk); #2;
      start = 0;
    end
    wait_c = 0;
    do begin @(negedge clk); wait_c++; end while (!done);
    if (n == 0) check(wait_c == 1, "R10", "done latency", wait_c, 1);
    check(expq.size() == 0, req, "pairs left at done", expq.size(), 0);
    if (rmode == 0 && !poke) check(gap_cycles == 0, "R12", "idle gaps", gap_cycles, 0);
    @(negedge clk);
    check(!done && !busy, "R7", "idle after done", int'({done, busy}), 0);
    expq.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !out_valid && !done, "R1", "reset outputs",
          int'({busy, out_valid, done}), 0);
    rst_n = 1;
    // R3 vector-vector, mixed masks
    run("R3", 8, 16'h00b5, 16'h00e6, 1, 1, 2, 10, 0, 0, 0, 0, 0, 0);
    run("R3", 16, 16'hf0f0, 16'h0ff1, 1, 1, 0, 16, 0, 0, 0, 0, 1, 0);
    // R4 scalar source, vector destination (source mask ignored)
    run("R4", 10, 16'h0000, 16'h0255, 0, 1, 7, 4, 0, 0, 0, 0, 1, 0);
    // R5 vector source, scalar destination (destination mask ignored)
    run("R5", 12, 16'h0a0c, 16'h0000, 1, 0, 1, 30, 0, 0, 0, 0, 0, 0);
    // R6 both scalar
    run("R6", 5, 16'h0000, 16'h0000, 0, 0, 12, 20, 0, 0, 0, 0, 1, 0);
    // R2 redirection on both sides, wrap of register number
    run("R2", 6, 16'h003f, 16'h002d, 1, 1, 1, 2, 1, 29, 1, 17, 0, 0);
    // R10 empty cases
    run("R10", 0, 16'hffff, 16'hffff, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    run("R10", 0, 16'h0000, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run("R10", 8, 16'hff00, 16'h00ff, 1, 1, 0, 8, 0, 0, 0, 0, 0, 0);
    // R11 mask bits past vl
    run("R11", 4, 16'hfff5, 16'hffff, 1, 1, 0, 8, 0, 0, 0, 0, 0, 0);
    run("R11", 3, 16'h0000, 16'hfff8, 0, 1, 5, 8, 0, 0, 0, 0, 0, 0);
    // Full length, all ones
    run("R3", 16, 16'hffff, 16'hffff, 1, 1, 0, 16, 0, 0, 0, 0, 0, 0);
    // R9 start while busy
    run("R9", 16, 16'h5555, 16'hffff, 1, 1, 0, 20, 0, 0, 0, 0, 1, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule